// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page-table entries. Each slot holds a virtual page number, a 4-bit address-space tag, a page frame number, protection bits, and dirty, accessed and valid flags. A lookup presents a virtual page number together with the current address-space tag. Every valid slot is compared against both at the same time. A hit returns the frame number, the protection bits and the updated flags one clock later.

A miss raises a miss flag and holds the missing page number and tag. The block then waits for an external page walker to supply the entry. The walker writes entries through a fill port. A fill goes to the lowest-numbered empty slot, or to the least recently used slot when no slot is empty. Software can drop every entry, or only the entries of one address space, so a context switch does not need to empty the whole cache.

Control is a two-state machine. In READY it accepts lookups. The transition READY→MISS_WAIT happens on a lookup that misses. In MISS_WAIT lookups are ignored, and the transition MISS_WAIT→READY happens on any fill. A fill made in READY is a preload and does not change state.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is empty, the state is READY, and rsp_valid, rsp_hit, dup_err and miss are all low.
- R2: A lookup hits only when a valid slot matches both req_vpn and req_asid. One cycle after the lookup edge, rsp_valid and rsp_hit are high and rsp_pfn/rsp_prot carry that slot's contents.
- R3: A lookup that matches no slot gives rsp_valid=1 and rsp_hit=0 one cycle later, and moves the block to MISS_WAIT. miss then stays high, with miss_vpn/miss_asid holding the request, until a fill is taken.
- R4: In MISS_WAIT a lookup request is ignored: no response is produced and no slot flag changes.
- R5: A fill writes the supplied page number, tag, frame and protection with the dirty and accessed flags cleared. The fill goes to the lowest-numbered empty slot when one exists. A fill taken in MISS_WAIT returns the block to READY.
- R6: When no slot is empty, a fill replaces the least recently used slot. Both a lookup hit and a fill count as a use of the slot.
- R7: Any hit sets the slot's accessed flag, and a hit with req_store=1 also sets its dirty flag. rsp_mod and rsp_ref report the flags after this update.
- R8: flush_all empties every slot. The effect is visible from the next cycle.
- R9: flush_one empties exactly the slots whose tag equals flush_asid. Slots of other tags stay intact.
- R10: When a lookup matches more than one valid slot, dup_err is high together with the response. The hit data then comes from the lowest-numbered matching slot.
- R11: In the same cycle, flush_all takes priority over flush_one, which takes priority over a fill, which takes priority over a lookup. A lower-priority request in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_store | input | 1 | Lookup is a store |
| req_vpn | input | VPN_W | Lookup virtual page number |
| req_asid | input | ASID_W | Current address-space tag |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_pfn | output | PFN_W | Frame number on hit |
| rsp_prot | output | PROT_W | Protection bits on hit |
| rsp_mod | output | 1 | Dirty flag after update |
| rsp_ref | output | 1 | Accessed flag after update |
| dup_err | output | 1 | Lookup matched more than one slot |
| miss | output | 1 | Waiting for a fill |
| miss_vpn | output | VPN_W | Page number that missed |
| miss_asid | output | ASID_W | Tag that missed |
| fill_valid | input | 1 | Write an entry |
| fill_vpn | input | VPN_W | Page number of the entry |
| fill_asid | input | ASID_W | Tag of the entry |
| fill_pfn | input | PFN_W | Frame number of the entry |
| fill_prot | input | PROT_W | Protection bits of the entry |
| flush_all | input | 1 | Empty every slot |
| flush_one | input | 1 | Empty slots of one tag |
| flush_asid | input | ASID_W | Tag to empty |

## Verification
A lookup sampled at a rising edge produces its response, its dup_err and, on a miss, the miss flag with the held page number, all from the registers updated at that same edge. They can be read before the next edge. Fills and flushes change slot contents at their edge, so their effect first shows in the response to a lookup taken at a later edge. The bench drives each request at a falling edge and advances its behavioural model at the following rising edge. It then compares every output with the model at the next falling edge, so each result is read exactly one register stage after its stimulus.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic {
        ST_READY     = 1'b0,
        ST_MISS_WAIT = 1'b1
    } tlb_state_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 4
) (
    input  logic [ENTRIES-1:0]             slot_valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  slot_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] slot_asid,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic [ENTRIES-1:0]             match
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = slot_valid[i]
                       && (slot_vpn[i] == key_vpn)
                       && (slot_asid[i] == key_asid);
    end
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] vec,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0][IDX_W-1:0] age_q;
    logic [ENTRIES-1:0]            is_old;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)          age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_old
        assign is_old[i] = (age_q[i] == OLDEST);
    end

    tlb_pick #(.ENTRIES(ENTRIES)) u_old_pick (
        .vec (is_old),
        .any (),
        .idx (victim)
    );

    // R6
    oldest_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_old) == 1);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 16,
    parameter int PROT_W  = 3,
    parameter int ASID_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [PROT_W-1:0] rsp_prot,
    output logic              rsp_mod,
    output logic              rsp_ref,
    output logic              dup_err,
    output logic              miss,
    output logic [VPN_W-1:0]  miss_vpn,
    output logic [ASID_W-1:0] miss_asid,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic              flush_all,
    input  logic              flush_one,
    input  logic [ASID_W-1:0] flush_asid
);
    localparam int IDX_W = $clog2(ENTRIES);

    tlb_state_e state_q, state_d;

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
    logic [ENTRIES-1:0][PROT_W-1:0] prot_q;
    logic [ENTRIES-1:0]             mod_q;
    logic [ENTRIES-1:0]             ref_q;

    logic              rsp_valid_q, rsp_hit_q, rsp_mod_q, rsp_ref_q, dup_q;
    logic [PFN_W-1:0]  rsp_pfn_q;
    logic [PROT_W-1:0] rsp_prot_q;
    logic [VPN_W-1:0]  miss_vpn_q;
    logic [ASID_W-1:0] miss_asid_q;

    logic [ENTRIES-1:0] match;
    logic               hit, has_free, multi;
    logic [IDX_W-1:0]   hit_idx, free_idx, victim, fill_slot, touch_idx;
    logic               do_flush_all, do_flush_one, do_fill, do_lookup, touch;

    // request arbitration: flush_all > flush_one > fill > lookup
    assign do_flush_all = flush_all;
    assign do_flush_one = !flush_all && flush_one;
    assign do_fill      = !flush_all && !flush_one && fill_valid;
    assign do_lookup    = !flush_all && !flush_one && !fill_valid
                       && req_valid && (state_q == ST_READY);

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam (
        .slot_valid (valid_q),
        .slot_vpn   (vpn_q),
        .slot_asid  (asid_q),
        .key_vpn    (req_vpn),
        .key_asid   (req_asid),
        .match      (match)
    );

    tlb_pick #(.ENTRIES(ENTRIES)) u_hit_pick (
        .vec (match),
        .any (hit),
        .idx (hit_idx)
    );

    tlb_pick #(.ENTRIES(ENTRIES)) u_free_pick (
        .vec (~valid_q),
        .any (has_free),
        .idx (free_idx)
    );

    tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    assign multi     = |(match & (match - ENTRIES'(1)));
    assign fill_slot = has_free ? free_idx : victim;
    assign touch     = do_fill || (do_lookup && hit);
    assign touch_idx = do_fill ? fill_slot : hit_idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:     if (do_lookup && !hit) state_d = ST_MISS_WAIT;
            ST_MISS_WAIT: if (do_fill)           state_d = ST_READY;
        endcase
    end

    // slot storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            vpn_q   <= '0;
            asid_q  <= '0;
            pfn_q   <= '0;
            prot_q  <= '0;
            mod_q   <= '0;
            ref_q   <= '0;
        end else if (do_flush_all) begin
            valid_q <= '0;
        end else if (do_flush_one) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (asid_q[i] == flush_asid) valid_q[i] <= 1'b0;
            end
        end else if (do_fill) begin
            valid_q[fill_slot] <= 1'b1;
            vpn_q[fill_slot]   <= fill_vpn;
            asid_q[fill_slot]  <= fill_asid;
            pfn_q[fill_slot]   <= fill_pfn;
            prot_q[fill_slot]  <= fill_prot;
            mod_q[fill_slot]   <= 1'b0;
            ref_q[fill_slot]   <= 1'b0;
        end else if (do_lookup && hit) begin
            ref_q[hit_idx] <= 1'b1;
            if (req_store) mod_q[hit_idx] <= 1'b1;
        end
    end

    // response and miss capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            dup_q       <= 1'b0;
            rsp_pfn_q   <= '0;
            rsp_prot_q  <= '0;
            rsp_mod_q   <= 1'b0;
            rsp_ref_q   <= 1'b0;
            miss_vpn_q  <= '0;
            miss_asid_q <= '0;
        end else begin
            rsp_valid_q <= do_lookup;
            rsp_hit_q   <= do_lookup && hit;
            dup_q       <= do_lookup && multi;
            if (do_lookup && hit) begin
                rsp_pfn_q  <= pfn_q[hit_idx];
                rsp_prot_q <= prot_q[hit_idx];
                rsp_mod_q  <= mod_q[hit_idx] || req_store;
                rsp_ref_q  <= 1'b1;
            end else begin
                rsp_pfn_q  <= '0;
                rsp_prot_q <= '0;
                rsp_mod_q  <= 1'b0;
                rsp_ref_q  <= 1'b0;
            end
            if (do_lookup && !hit) begin
                miss_vpn_q  <= req_vpn;
                miss_asid_q <= req_asid;
            end
        end
    end

    // outputs
    always_comb begin
        rsp_valid = rsp_valid_q;
        rsp_hit   = rsp_hit_q;
        rsp_pfn   = rsp_pfn_q;
        rsp_prot  = rsp_prot_q;
        rsp_mod   = rsp_mod_q;
        rsp_ref   = rsp_ref_q;
        dup_err   = dup_q;
        miss      = (state_q == ST_MISS_WAIT);
        miss_vpn  = miss_vpn_q;
        miss_asid = miss_asid_q;
    end

    // R3
    miss_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY && do_lookup && !hit) |=> (state_q == ST_MISS_WAIT));

    // R3
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MISS_WAIT) |=> ($stable(miss_vpn_q) && $stable(miss_asid_q)));

    // R4
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MISS_WAIT) |=> !rsp_valid_q);

    // R7
    hit_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit_q |-> (rsp_ref_q && rsp_valid_q));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));

    // R10
    dup_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dup_q |-> rsp_hit_q);
endmodule

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb;
    localparam int N      = 16;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 16;
    localparam int PROT_W = 3;
    localparam int ASID_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_store = 0;
    logic [VPN_W-1:0] req_vpn = '0;
    logic [ASID_W-1:0] req_asid = '0;
    logic rsp_valid, rsp_hit, rsp_mod, rsp_ref, dup_err, miss;
    logic [PFN_W-1:0] rsp_pfn;
    logic [PROT_W-1:0] rsp_prot;
    logic [VPN_W-1:0] miss_vpn;
    logic [ASID_W-1:0] miss_asid;
    logic fill_valid = 0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic [PROT_W-1:0] fill_prot = '0;
    logic flush_all = 0, flush_one = 0;
    logic [ASID_W-1:0] flush_asid = '0;

    always #2.5 clk = ~clk;

    asid_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .PROT_W(PROT_W), .ASID_W(ASID_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_store(req_store), .req_vpn(req_vpn), .req_asid(req_asid),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_prot(rsp_prot),
        .rsp_mod(rsp_mod), .rsp_ref(rsp_ref), .dup_err(dup_err),
        .miss(miss), .miss_vpn(miss_vpn), .miss_asid(miss_asid),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_prot(fill_prot),
        .flush_all(flush_all), .flush_one(flush_one), .flush_asid(flush_asid)
    );

    int total = 0;
    int bad = 0;

    // behavioural reference model
    bit m_val[N];
    int m_vpn[N], m_asid[N], m_pfn[N], m_prot[N];
    bit m_mod[N], m_ref[N];
    int recent[$];   // front = most recently used slot
    bit m_miss;
    int m_mvpn, m_masid;
    bit e_rv, e_hit, e_dup, e_mod, e_ref;
    int e_pfn, e_prot;

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic use_slot(input int s);
        foreach (recent[k]) begin
            if (recent[k] == s) begin
                recent.delete(k);
                break;
            end
        end
        recent.push_front(s);
    endtask

    task automatic model_reset();
        recent.delete();
        for (int i = 0; i < N; i++) begin
            m_val[i] = 0; m_mod[i] = 0; m_ref[i] = 0;
            recent.push_back(i);
        end
        m_miss = 0; e_rv = 0; e_hit = 0; e_dup = 0;
    endtask

    task automatic model_step();
        e_rv = 0; e_hit = 0; e_dup = 0;
        if (flush_all) begin
            for (int i = 0; i < N; i++) m_val[i] = 0;
        end else if (flush_one) begin
            for (int i = 0; i < N; i++) if (m_asid[i] == int'(flush_asid)) m_val[i] = 0;
        end else if (fill_valid) begin
            int s = -1;
            for (int i = 0; i < N; i++) if (!m_val[i] && s < 0) s = i;
            if (s < 0) s = recent[$];
            m_val[s] = 1; m_vpn[s] = int'(fill_vpn); m_asid[s] = int'(fill_asid);
            m_pfn[s] = int'(fill_pfn); m_prot[s] = int'(fill_prot);
            m_mod[s] = 0; m_ref[s] = 0;
            use_slot(s);
            m_miss = 0;
        end else if (req_valid && !m_miss) begin
            int first = -1;
            int cnt = 0;
            e_rv = 1;
            for (int i = 0; i < N; i++) begin
                if (m_val[i] && m_vpn[i] == int'(req_vpn) && m_asid[i] == int'(req_asid)) begin
                    cnt++;
                    if (first < 0) first = i;
                end
            end
            if (first >= 0) begin
                e_hit = 1; e_dup = (cnt > 1);
                m_ref[first] = 1;
                if (req_store) m_mod[first] = 1;
                e_pfn = m_pfn[first]; e_prot = m_prot[first];
                e_mod = m_mod[first]; e_ref = 1;
                use_slot(first);
            end else begin
                m_miss = 1; m_mvpn = int'(req_vpn); m_masid = int'(req_asid);
            end
        end
    endtask

    task automatic compare();
        chk("R2/R4 rsp_valid", rsp_valid, e_rv);
        chk("R2 rsp_hit", rsp_hit, e_hit);
        chk("R10 dup_err", dup_err, e_dup);
        chk("R3 miss", miss, m_miss);
        if (e_hit) begin
            chk("R2 rsp_pfn", rsp_pfn, e_pfn);
            chk("R2 rsp_prot", rsp_prot, e_prot);
            chk("R7 rsp_mod", rsp_mod, e_mod);
            chk("R7 rsp_ref", rsp_ref, e_ref);
        end
        if (m_miss) begin
            chk("R3 miss_vpn", miss_vpn, m_mvpn);
            chk("R3 miss_asid", miss_asid, m_masid);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        req_valid = 0; req_store = 0; fill_valid = 0; flush_all = 0; flush_one = 0;
    endtask

    task automatic lookup(input int v, input int a, input bit st);
        req_valid = 1; req_store = st; req_vpn = VPN_W'(v); req_asid = ASID_W'(a);
        cyc();
    endtask

    task automatic fill(input int v, input int a, input int p, input int pr);
        fill_valid = 1; fill_vpn = VPN_W'(v); fill_asid = ASID_W'(a);
        fill_pfn = PFN_W'(p); fill_prot = PROT_W'(pr);
        cyc();
    endtask

    task automatic flush_every();
        flush_all = 1;
        cyc();
    endtask

    task automatic flush_tag(input int a);
        flush_one = 1; flush_asid = ASID_W'(a);
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        // R1: reset state
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 rsp_hit", rsp_hit, 0);
        chk("R1 dup_err", dup_err, 0);
        chk("R1 miss", miss, 0);
        lookup(5, 0, 0);
        chk("R1 empty cache misses", rsp_hit, 0);
        fill(5, 0, 16'h55, 1);

        // R3: miss then hold
        lookup(32'h100, 1, 0);
        chk("R3 miss raised", miss, 1);
        chk("R3 miss_vpn held", miss_vpn, 32'h100);
        // R4: lookups ignored while waiting
        lookup(5, 0, 1);
        chk("R4 ignored lookup", rsp_valid, 0);
        // R5: fill returns to READY
        fill(32'h100, 1, 16'hA1, 5);
        chk("R5 miss cleared", miss, 0);
        lookup(5, 0, 0);
        chk("R4 ignored store left dirty clear", rsp_mod, 0);
        // R7: load then store
        lookup(32'h100, 1, 0);
        chk("R7 load ref", rsp_ref, 1);
        chk("R7 load mod", rsp_mod, 0);
        lookup(32'h100, 1, 1);
        chk("R7 store mod", rsp_mod, 1);
        // R2: tag must match
        lookup(32'h100, 2, 0);
        chk("R2 other tag misses", rsp_hit, 0);
        fill(32'h100, 2, 16'hB2, 3);
        lookup(32'h100, 2, 0);
        chk("R2 own tag pfn", rsp_pfn, 16'hB2);
        lookup(32'h100, 1, 0);
        chk("R2 tag 1 still present", rsp_pfn, 16'hA1);

        // R8: flush everything
        flush_every();
        lookup(32'h100, 1, 0);
        chk("R8 flushed entry misses", rsp_hit, 0);
        fill(32'h100, 1, 16'hA1, 5);

        // R6: fill all slots, then replacement of least recently used
        flush_every();
        for (int i = 0; i < N; i++) fill(32'h200 + i, 3, 16'h1000 + i, i % 8);
        lookup(32'h200, 3, 0);
        chk("R6 refreshed slot hits", rsp_hit, 1);
        fill(32'h300, 3, 16'h2000, 2);
        lookup(32'h201, 3, 0);
        chk("R6 oldest evicted", rsp_hit, 0);
        fill(32'h201, 3, 16'h1001, 1);
        lookup(32'h200, 3, 0);
        chk("R6 recently used kept", rsp_hit, 1);
        lookup(32'h202, 3, 0);
        chk("R6 second oldest evicted", rsp_hit, 0);
        fill(32'h202, 3, 16'h1002, 2);
        lookup(32'h300, 3, 0);
        chk("R5 preload present", rsp_pfn, 16'h2000);

        // R9: flush one tag only
        flush_every();
        fill(32'h400, 1, 16'h0401, 1);
        fill(32'h401, 3, 16'h0403, 3);
        flush_tag(3);
        lookup(32'h401, 3, 0);
        chk("R9 tag 3 removed", rsp_hit, 0);
        fill(32'h401, 3, 16'h0403, 3);
        lookup(32'h400, 1, 0);
        chk("R9 tag 1 kept", rsp_hit, 1);

        // R10: duplicate entries
        flush_every();
        fill(32'h500, 2, 16'h0111, 1);
        fill(32'h500, 2, 16'h0222, 2);
        lookup(32'h500, 2, 0);
        chk("R10 dup flagged", dup_err, 1);
        chk("R10 lowest slot wins", rsp_pfn, 16'h0111);

        // R11: same-cycle priority
        flush_all = 1; flush_one = 1; fill_valid = 1; fill_vpn = 20'h600;
        fill_asid = 4'd1; fill_pfn = 16'h0600; req_valid = 1; req_vpn = 20'h500; req_asid = 4'd2;
        cyc();
        chk("R11 lookup dropped under flush", rsp_valid, 0);
        lookup(32'h600, 1, 0);
        chk("R11 fill dropped under flush", rsp_hit, 0);
        fill(32'h600, 1, 16'h0600, 4);
        fill_valid = 1; fill_vpn = 20'h700; fill_asid = 4'd1; fill_pfn = 16'h0700;
        req_valid = 1; req_vpn = 20'h600; req_asid = 4'd1;
        cyc();
        chk("R11 lookup dropped under fill", rsp_valid, 0);
        lookup(32'h700, 1, 0);
        chk("R11 fill taken", rsp_pfn, 16'h0700);
        flush_one = 1; flush_asid = 4'd1; fill_valid = 1; fill_vpn = 20'h800;
        fill_asid = 4'd1; fill_pfn = 16'h0800;
        cyc();
        lookup(32'h800, 1, 0);
        chk("R11 fill dropped under tag flush", rsp_hit, 0);
        fill(32'h800, 1, 16'h0800, 0);

        repeat (2) cyc();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule